// File: doc/BRIEF.md
# External Interrupt Pin Flag Latch

This block watches a set of external interrupt pins and keeps one pending flag per pin. Each pin has its own detection mode: active-low level, falling edge, rising edge, or either edge. A flag that has been set stays set until one of two things clears it.

The first is software. A status read must have returned 1 for that bit, and a later status write must then carry 0 in that bit. The second is the processor's acknowledge for that interrupt. In edge modes the acknowledge always clears the flag. In level mode it clears the flag only if the synchronised pin has already returned high.

The flags drive the request outputs directly. Arbitration between requests, masking and vectoring belong to logic outside this block. Software reaches the flags and the mode settings through a one-cycle register port with two addresses.

Top module: `irq_flag_ctrl`

## Requirements
- R1: The status register sits at address 0. Bit n (0 to 14) holds the flag of pin n. Bits 31 to 15 always read 0, and writing them has no effect.
- R2: The mode register sits at address 1. Pin n owns bits [2n+1:2n], with 00 = low level, 01 = falling edge, 10 = rising edge and 11 = either edge. It reads back what was written, and bits 31 to 30 read 0.
- R3: After reset, every flag is 0 and every mode field is 00.
- R4: Writing 1 to a status bit never sets a flag.
- R5: A status write with 0 in bit n clears flag n only if a status read returned 1 in bit n after the last status write. Any status write uses up that permission, whatever value it carries.
- R6: In low-level mode, a flag is set when the pin is low. The request output rises on the third rising clock edge after the pin falls.
- R7: Falling mode sets the flag only on a high-to-low transition. Rising mode sets it only on a low-to-high transition. Either-edge mode sets it on both. A transition the mode does not select leaves the flag at 0.
- R8: In low-level mode, an acknowledge clears the flag only if the synchronised pin is high. When the pin is still low, the flag stays set. A flag whose pin has gone high stays latched until it is cleared.
- R9: In any edge mode, an acknowledge clears the flag on the next clock edge.
- R10: If a set condition and a clear fall on the same cycle, the flag stays set.
- R11: Request output n equals flag n at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | 0 = status, 1 = mode |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, valid in the same cycle |
| irq_pin | input | 15 | Raw interrupt pins, idle high |
| irq_ack | input | 15 | Per-pin acknowledge of exception handling, one cycle |
| irq_req | output | 15 | Per-pin pending request (the flags) |

## Verification
Read data is combinational, so a read is checked in the cycle its strobe is high. A read arms the clear permission at the edge that ends that cycle. A pin change passes two synchroniser flops before the flag register, so the bench first confirms the request is still 0 just before the third edge and then 1 just after it. Writes and acknowledges take effect on the edge that ends their cycle. Each expected value is queued by the driver and compared at the falling clock edge inside the cycle the monitor is pointed at, so no sample races the edge that updates it.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_SENSE  = 1'b1;

    // One pin's synchronised view: current sample and the one before
    typedef struct packed {
        logic cur;
        logic prv;
    } pin_view_t;

    function automatic logic sense_hit(sense_e mode, pin_view_t v);
        logic hit;
        case (mode)
            SENSE_LOW:  hit = ~v.cur;
            SENSE_FALL: hit = v.prv & ~v.cur;
            SENSE_RISE: hit = ~v.prv & v.cur;
            SENSE_BOTH: hit = v.prv ^ v.cur;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic ack_allowed(sense_e mode, pin_view_t v);
        return (mode != SENSE_LOW) | v.cur;
    endfunction

endpackage

// File: rtl/irqf_pin_sense.sv
module irqf_pin_sense
    import irqf_pkg::*;
#(
    parameter int N_IRQ = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_IRQ-1:0]     pin_raw,
    input  logic [2*N_IRQ-1:0]   sense_flat,
    output logic [N_IRQ-1:0]     set_cond,
    output logic [N_IRQ-1:0]     ack_ok,
    output logic [N_IRQ-1:0]     pin_sync
);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
        logic      meta_q;
        pin_view_t view_q;
        sense_e    mode;

        // Reset to idle-high so that no edge or low level appears at start-up
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                view_q <= '{cur: 1'b1, prv: 1'b1};
            end else begin
                meta_q     <= pin_raw[i];
                view_q.cur <= meta_q;
                view_q.prv <= view_q.cur;
            end
        end

        assign mode        = sense_e'(sense_flat[2*i +: 2]);
        assign set_cond[i] = sense_hit(mode, view_q);
        assign ack_ok[i]   = ack_allowed(mode, view_q);
        assign pin_sync[i] = view_q.cur;
    end

endmodule

// File: rtl/irqf_sense_reg.sv
module irqf_sense_reg
    import irqf_pkg::*;
#(
    parameter int N_IRQ = 15,
    localparam int SENSE_W = 2 * N_IRQ
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SENSE_W-1:0] wdata,
    output logic [SENSE_W-1:0] sense_flat
);

    always_ff @(posedge clk) begin
        if (rst)        sense_flat <= '0;
        else if (wr_en) sense_flat <= wdata;
    end

    a_r3_mode_reset: assert property (@(posedge clk)
        rst |=> (sense_flat == '0));

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sense_flat));

endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank
    import irqf_pkg::*;
#(
    parameter int N_IRQ = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] set_cond,
    input  logic [N_IRQ-1:0] ack,
    input  logic [N_IRQ-1:0] ack_ok,
    input  logic             rd_stat,
    input  logic             wr_stat,
    input  logic [N_IRQ-1:0] wdata,
    output logic [N_IRQ-1:0] flags
);

    logic [N_IRQ-1:0] armed_q;
    logic [N_IRQ-1:0] hw_clr, sw_clr, flag_nxt, armed_nxt;

    always_comb begin
        hw_clr    = ack & ack_ok;
        sw_clr    = {N_IRQ{wr_stat}} & armed_q & ~wdata;
        flag_nxt  = set_cond | (flags & ~(hw_clr | sw_clr));
        armed_nxt = flag_nxt & ~{N_IRQ{wr_stat}} & (armed_q | ({N_IRQ{rd_stat}} & flags));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            armed_q <= '0;
        end else begin
            flags   <= flag_nxt;
            armed_q <= armed_nxt;
        end
    end

    // R4: a flag only rises when the pin logic requested it
    a_r4_rise_from_pin: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~$past(flags) & ~$past(set_cond)) == '0));

    // R5: a flag only falls after an acknowledge or a status write
    a_r5_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
        ((~flags & $past(flags) & ~$past(ack | {N_IRQ{wr_stat}})) == '0));

    // R10: a pending set condition always leaves the flag at 1
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        ((~flags & $past(set_cond)) == '0));

    a_r5_no_write_no_read_no_clear: assert property (@(posedge clk) disable iff (rst)
        (!wr_stat && ack == '0) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqf_pkg::*;
#(
    parameter int N_IRQ  = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_IRQ-1:0]  irq_pin,
    input  logic [N_IRQ-1:0]  irq_ack,
    output logic [N_IRQ-1:0]  irq_req
);

    localparam int SENSE_W = 2 * N_IRQ;

    logic [SENSE_W-1:0] sense_flat;
    logic [N_IRQ-1:0]   set_cond, ack_ok, pin_sync, flags;
    logic               rd_stat, wr_stat, wr_sense;
    logic               unused_wdata;

    assign rd_stat  = reg_rd & (reg_addr == ADDR_STATUS);
    assign wr_stat  = reg_wr & (reg_addr == ADDR_STATUS);
    assign wr_sense = reg_wr & (reg_addr == ADDR_SENSE);
    assign unused_wdata = ^reg_wdata[DATA_W-1:SENSE_W];

    irqf_sense_reg #(.N_IRQ(N_IRQ)) u_sense (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_sense),
        .wdata      (reg_wdata[SENSE_W-1:0]),
        .sense_flat (sense_flat)
    );

    irqf_pin_sense #(.N_IRQ(N_IRQ)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (irq_pin),
        .sense_flat (sense_flat),
        .set_cond   (set_cond),
        .ack_ok     (ack_ok),
        .pin_sync   (pin_sync)
    );

    irqf_flag_bank #(.N_IRQ(N_IRQ)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_cond (set_cond),
        .ack      (irq_ack),
        .ack_ok   (ack_ok),
        .rd_stat  (rd_stat),
        .wr_stat  (wr_stat),
        .wdata    (reg_wdata[N_IRQ-1:0]),
        .flags    (flags)
    );

    always_comb begin
        if (reg_addr == ADDR_STATUS) reg_rdata = {{(DATA_W-N_IRQ){1'b0}}, flags};
        else                         reg_rdata = {{(DATA_W-SENSE_W){1'b0}}, sense_flat};
    end

    assign irq_req = flags;

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_STATUS) |-> (reg_rdata[DATA_W-1:N_IRQ] == '0));

    for (genvar i = 0; i < N_IRQ; i++) begin : g_chk
        // R8: a low-level acknowledge while the pin is still low keeps the request
        a_r8_level_ack_hold: assert property (@(posedge clk) disable iff (rst)
            (sense_flat[2*i +: 2] == SENSE_LOW && irq_ack[i] && !pin_sync[i] && irq_req[i])
            |=> irq_req[i]);
    end

endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 15;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_rd, reg_wr, reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  irq_pin, irq_ack, irq_req;

    irq_flag_ctrl dut (
        .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pin(irq_pin), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          is_req;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    mon_go = 1'b0;
    bit    done = 1'b0;

    // Monitor: compares at the falling edge of a cycle the driver marked
    always @(negedge clk) begin
        if (mon_go) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: no expected item queued");
            end else begin
                item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = it.is_req ? {17'b0, irq_req} : reg_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd_expect(logic addr, logic [31:0] exp, string tag);
        exp_q.push_back('{is_req: 1'b0, exp: exp, tag: tag});
        reg_rd = 1'b1; reg_addr = addr; mon_go = 1'b1;
        step(1);
        reg_rd = 1'b0; mon_go = 1'b0;
    endtask

    task automatic req_expect(logic [31:0] exp, string tag);
        exp_q.push_back('{is_req: 1'b1, exp: exp, tag: tag});
        mon_go = 1'b1;
        step(1);
        mon_go = 1'b0;
    endtask

    task automatic wr(logic addr, logic [31:0] data);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        step(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic ack(logic [N-1:0] m);
        irq_ack = m;
        step(1);
        irq_ack = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        irq_pin = '1; irq_ack = '0;
        step(4);
        rst = 1'b0;
        step(1);

        // R3 reset state
        rd_expect(1'b0, 32'h0, "R3 status after reset");
        rd_expect(1'b1, 32'h0, "R3 mode after reset");
        req_expect(32'h0, "R11 requests after reset");

        // R1 / R4: writing ones sets nothing, upper bits read 0
        wr(1'b0, 32'hFFFF_FFFF);
        rd_expect(1'b0, 32'h0, "R1 R4 status after all-ones write");
        // R2 field width and read-back
        wr(1'b1, 32'hFFFF_FFFF);
        rd_expect(1'b1, 32'h3FFF_FFFF, "R2 mode upper bits read 0");
        wr(1'b1, 32'h0);
        rd_expect(1'b1, 32'h0, "R2 mode cleared");

        // R6: low level on pin 0, latency of three edges
        irq_pin[0] = 1'b0;
        step(2);
        req_expect(32'h0, "R6 not yet before third edge");
        req_expect(32'h1, "R6 set on third edge");
        rd_expect(1'b0, 32'h1, "R1 status bit 0");

        // R8: acknowledge while pin low keeps the flag
        wr(1'b0, 32'h0);  // consumes the arm from the read above, pin low re-sets anyway
        ack(15'h1);
        req_expect(32'h1, "R8 ack with pin low keeps flag");
        irq_pin[0] = 1'b1;
        step(3);
        req_expect(32'h1, "R8 flag latched after pin high");
        ack(15'h1);
        req_expect(32'h0, "R8 ack with pin high clears");

        // R5: falling mode on pin 3 (field 3 = 01)
        wr(1'b1, 32'h0000_0040);
        irq_pin[3] = 1'b0;
        step(3);
        req_expect(32'h8, "R7 falling edge sets pin 3");
        wr(1'b0, 32'h0);
        req_expect(32'h8, "R5 zero write without read ignored");
        rd_expect(1'b0, 32'h8, "R5 read arms bit 3");
        wr(1'b0, 32'hFFFF_FFF7);
        rd_expect(1'b0, 32'h0, "R5 zero write after read clears");
        irq_pin[3] = 1'b1;
        step(3);
        req_expect(32'h0, "R7 rising edge ignored in falling mode");
        irq_pin[3] = 1'b0;
        step(3);
        rd_expect(1'b0, 32'h8, "R5 re-armed read");
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b0, 32'h0);
        rd_expect(1'b0, 32'h8, "R5 intervening write consumed the arm");
        ack(15'h8);
        req_expect(32'h0, "R9 edge-mode ack clears pin 3");

        // R7 / R9: rising mode on pin 7 (field 7 = 10)
        wr(1'b1, 32'h0000_8040);
        irq_pin[7] = 1'b0;
        step(3);
        req_expect(32'h0, "R7 falling edge ignored in rising mode");
        irq_pin[7] = 1'b1;
        step(3);
        req_expect(32'h80, "R7 rising edge sets pin 7");
        ack(15'h80);
        req_expect(32'h0, "R9 ack clears pin 7");

        // R7: either edge on pin 14 (field 14 = 11)
        wr(1'b1, 32'h3000_8040);
        rd_expect(1'b1, 32'h3000_8040, "R2 mode read-back");
        irq_pin[14] = 1'b0;
        step(3);
        req_expect(32'h4000, "R7 both-edge mode falling sets");
        rd_expect(1'b0, 32'h4000, "R1 status bit 14");
        wr(1'b0, 32'h0);
        req_expect(32'h0, "R5 software clear pin 14");
        irq_pin[14] = 1'b1;
        step(3);
        req_expect(32'h4000, "R7 both-edge mode rising sets");
        ack(15'h4000);
        req_expect(32'h0, "R9 ack clears pin 14");

        // R10: set condition beats software clear (pin 2, low level)
        irq_pin[2] = 1'b0;
        step(3);
        rd_expect(1'b0, 32'h4, "R10 flag 2 set and armed");
        wr(1'b0, 32'h0);
        rd_expect(1'b0, 32'h4, "R10 set wins over clear");
        irq_pin[2] = 1'b1;
        step(3);
        rd_expect(1'b0, 32'h4, "R8 level flag latched");
        wr(1'b0, 32'h0);
        req_expect(32'h0, "R5 clear once pin released");

        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule